// File: doc/BRIEF.md
# Timer Interrupt Flag Unit

This block keeps the interrupt flags of an eight-channel 16-bit timer. One flag register holds a flag per capture/compare channel; a second register holds the counter-overflow flag in its top bit. Each channel raises its flag when it sees a one-cycle event pulse from the capture or compare logic. The overflow flag rises on an overflow pulse from the counter. Every flag is ANDed with its own interrupt-enable input to form a level interrupt request. The request stays high until software clears the flag.

Software reads the flags over a simple synchronous byte bus at any time. It clears them by writing ones, and this works only while the timer or the pulse accumulator is enabled. A fast-clear mode is also available: any read or write of a channel's 16-bit register clears that channel's flag, and any access to the counter register clears the overflow flag. The counter, the capture and compare datapaths, the prescaler and the pulse accumulator live elsewhere. This block sees them only through their event pulses and through bus accesses to their addresses.

Top module: `tmr_flag_unit`

## Requirements
- R1: After reset both flag registers read as zero and no interrupt request is asserted.
- R2: An event pulse on channel n sets bit n of the channel flag register at offset 0x0E. An overflow pulse sets bit 7 of the overflow register at offset 0x0F. Each flag is visible on `rdata_o` one cycle after its pulse.
- R3: Bits 6 to 0 of the register at 0x0F always read as zero.
- R4: A write to 0x0E or 0x0F clears each flag whose data bit is one, provided `tmr_en_i` or `pac_en_i` is high. Flags whose data bit is zero are left unchanged.
- R5: While both `tmr_en_i` and `pac_en_i` are low, writes to 0x0E and 0x0F change no flag.
- R6: With `fast_clr_i` high, a read or write at offset 0x10+2n or 0x11+2n clears channel n's flag only.
- R7: With `fast_clr_i` high, a read or write at offset 0x04 or 0x05 clears the overflow flag, and leaves the channel flags unchanged.
- R8: With `fast_clr_i` low, accesses to the channel and counter offsets change no flag.
- R9: If a set pulse and a clear request of any kind reach the same flag in the same cycle, the flag ends up set.
- R10: `ch_irq_o[n]` equals channel flag n AND `ch_ie_i[n]`, and `ovf_irq_o` equals the overflow flag AND `ovf_ie_i`. Both are combinational and hold as long as the flag stays set.
- R11: `rdata_o` reads zero at every offset other than 0x0E and 0x0F. It depends only on `addr_i`, so inspecting it has no side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 6 | Bus byte offset |
| rd_i | input | 1 | Read strobe, one cycle per access |
| wr_i | input | 1 | Write strobe, one cycle per access |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the offset on addr_i (combinational) |
| ch_evt_i | input | 8 | Capture/compare event pulses, one per channel |
| ovf_evt_i | input | 1 | Counter overflow pulse |
| tmr_en_i | input | 1 | Timer enable |
| pac_en_i | input | 1 | Pulse accumulator enable |
| fast_clr_i | input | 1 | Fast flag-clear mode |
| ch_ie_i | input | 8 | Channel interrupt enables |
| ovf_ie_i | input | 1 | Overflow interrupt enable |
| ch_irq_o | output | 8 | Channel interrupt requests |
| ovf_irq_o | output | 1 | Overflow interrupt request |

## Verification
Set pulses and clear accesses both act at the next rising edge. The bench therefore drives each stimulus just after an edge and checks the flags through `rdata_o` one nanosecond after the following edge. `rdata_o` and the interrupt outputs are combinational from flag state, address and enables. They are sampled one nanosecond after the bench changes `addr_i` or an enable, with no clock edge in between. Because the readback offset is driven without a read strobe, the observation itself never triggers a fast clear.

// File: rtl/tmr_flag_pkg.sv
package tmr_flag_pkg;
  localparam int unsigned CNT_LO_OFS = 'h04;
  localparam int unsigned CNT_HI_OFS = 'h05;
  localparam int unsigned CH_FLG_OFS = 'h0E;
  localparam int unsigned OVF_FLG_OFS = 'h0F;
  localparam int unsigned CH_BASE_OFS = 'h10;
  localparam int unsigned BYTES_PER_CH = 2;
endpackage

// File: rtl/tmr_flag_bank.sv
module tmr_flag_bank #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] flag_o
);
  for (genvar k = 0; k < W; k++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_o[k] <= 1'b0;
      else if (set_i[k]) flag_o[k] <= 1'b1;  // set has priority
      else if (clr_i[k]) flag_o[k] <= 1'b0;
    end
  end
endmodule

// File: rtl/tmr_flag_dec.sv
module tmr_flag_dec
  import tmr_flag_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned NUM_CH = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [NUM_CH-1:0] wdata_i,
  input  logic              en_i,
  input  logic              fast_i,
  output logic [NUM_CH-1:0] ch_clr_o,
  output logic              ovf_clr_o
);
  logic acc;
  logic wr_ch_flg, wr_ovf_flg, cnt_hit;
  assign acc        = rd_i | wr_i;
  assign wr_ch_flg  = wr_i & en_i & (addr_i == ADDR_W'(CH_FLG_OFS));
  assign wr_ovf_flg = wr_i & en_i & (addr_i == ADDR_W'(OVF_FLG_OFS));
  assign cnt_hit    = (addr_i == ADDR_W'(CNT_LO_OFS)) | (addr_i == ADDR_W'(CNT_HI_OFS));

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    localparam int unsigned LO = CH_BASE_OFS + BYTES_PER_CH * k;
    logic hit;
    assign hit = (addr_i == ADDR_W'(LO)) | (addr_i == ADDR_W'(LO + 1));
    assign ch_clr_o[k] = (wr_ch_flg & wdata_i[k]) | (fast_i & acc & hit);
  end

  assign ovf_clr_o = (wr_ovf_flg & wdata_i[NUM_CH-1]) | (fast_i & acc & cnt_hit);
endmodule

// File: rtl/tmr_flag_unit.sv
module tmr_flag_unit
  import tmr_flag_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [DATA_W-1:0] ch_evt_i,
  input  logic              ovf_evt_i,
  input  logic              tmr_en_i,
  input  logic              pac_en_i,
  input  logic              fast_clr_i,
  input  logic [DATA_W-1:0] ch_ie_i,
  input  logic              ovf_ie_i,
  output logic [DATA_W-1:0] ch_irq_o,
  output logic              ovf_irq_o
);
  localparam int unsigned NUM_CH = DATA_W;

  logic [NUM_CH-1:0] ch_clr, ch_flag;
  logic              ovf_clr, ovf_flag;

  tmr_flag_dec #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) u_dec (
    .addr_i   (addr_i),
    .rd_i     (rd_i),
    .wr_i     (wr_i),
    .wdata_i  (wdata_i),
    .en_i     (tmr_en_i | pac_en_i),
    .fast_i   (fast_clr_i),
    .ch_clr_o (ch_clr),
    .ovf_clr_o(ovf_clr)
  );

  tmr_flag_bank #(.W(NUM_CH)) u_ch_bank (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (ch_evt_i),
    .clr_i (ch_clr),
    .flag_o(ch_flag)
  );

  tmr_flag_bank #(.W(1)) u_ovf_bank (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (ovf_evt_i),
    .clr_i (ovf_clr),
    .flag_o(ovf_flag)
  );

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(CH_FLG_OFS)) rdata_o = ch_flag;
    else if (addr_i == ADDR_W'(OVF_FLG_OFS)) rdata_o[DATA_W-1] = ovf_flag;
  end

  assign ch_irq_o  = ch_flag & ch_ie_i;
  assign ovf_irq_o = ovf_flag & ovf_ie_i;
endmodule

// File: rtl/tmr_flag_chk.sv
module tmr_flag_chk
  import tmr_flag_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [DATA_W-1:0] ch_evt_i,
  input logic              ovf_evt_i,
  input logic              tmr_en_i,
  input logic              pac_en_i,
  input logic              fast_clr_i,
  input logic [DATA_W-1:0] ch_ie_i,
  input logic [DATA_W-1:0] ch_irq_o,
  input logic              ovf_ie_i,
  input logic              ovf_irq_o,
  input logic [DATA_W-1:0] ch_flag,
  input logic              ovf_flag
);
  for (genvar k = 0; k < DATA_W; k++) begin : g_set
    assert_ch_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ch_evt_i[k] |=> ch_flag[k]);
  end

  assert_ovf_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_evt_i |=> ovf_flag);

  assert_no_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tmr_en_i && !pac_en_i && !fast_clr_i)
      |=> ((ch_flag & $past(ch_flag)) == $past(ch_flag)) && (ovf_flag || !$past(ovf_flag)));

  always_comb begin
    if (rst_ni) begin
      assert_irq_gated_R10: assert ((ch_irq_o & ~ch_ie_i) == '0 && (ovf_irq_o <= ovf_ie_i));
      if (addr_i == ADDR_W'(OVF_FLG_OFS))
        assert_rsvd_zero_R3: assert (rdata_o[DATA_W-2:0] == '0);
    end
  end
endmodule

bind tmr_flag_unit tmr_flag_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .rdata_o(rdata_o),
  .ch_evt_i(ch_evt_i), .ovf_evt_i(ovf_evt_i), .tmr_en_i(tmr_en_i),
  .pac_en_i(pac_en_i), .fast_clr_i(fast_clr_i), .ch_ie_i(ch_ie_i),
  .ch_irq_o(ch_irq_o), .ovf_ie_i(ovf_ie_i), .ovf_irq_o(ovf_irq_o),
  .ch_flag(ch_flag), .ovf_flag(ovf_flag)
);

// File: tb/tb_tmr_flag_unit.sv
`timescale 1ns/1ps
module tb_tmr_flag_unit;
  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic [5:0] addr_i = '0;
  logic       rd_i = 0, wr_i = 0;
  logic [7:0] wdata_i = '0, rdata_o, ch_evt_i = '0, ch_ie_i = '0, ch_irq_o;
  logic       ovf_evt_i = 0, tmr_en_i = 0, pac_en_i = 0, fast_clr_i = 0;
  logic       ovf_ie_i = 0, ovf_irq_o;
  int total = 0, bad = 0;

  always #2 clk_i = ~clk_i;

  tmr_flag_unit dut (.*);

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i); #1;
  endtask

  function automatic int rd_reg(logic [5:0] a);
    addr_i = a;
    return 0;
  endfunction

  task automatic peek(logic [5:0] a, output int v);
    addr_i = a; rd_i = 0; wr_i = 0; #1; v = rdata_o;
  endtask

  task automatic acc(bit r, bit w, logic [5:0] a, logic [7:0] d);
    addr_i = a; rd_i = r; wr_i = w; wdata_i = d;
    tick();
    rd_i = 0; wr_i = 0; ch_evt_i = '0; ovf_evt_i = 0;
  endtask

  task automatic set_all();
    ch_evt_i = 8'hFF; ovf_evt_i = 1; tick(); ch_evt_i = '0; ovf_evt_i = 0;
  endtask

  task automatic clear_all();
    tmr_en_i = 1; acc(0, 1, 6'h0E, 8'hFF); acc(0, 1, 6'h0F, 8'h80); tmr_en_i = 0;
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int v;
    #5 rst_ni = 1; #1;
    // R1
    peek(6'h0E, v); check("R1 ch", v, 0);
    peek(6'h0F, v); check("R1 ovf", v, 0);
    ch_ie_i = 8'hFF; ovf_ie_i = 1; #1;
    check("R1 irq", {ovf_irq_o, ch_irq_o}, 0);
    ch_ie_i = 0; ovf_ie_i = 0;
    tick();

    // R2: accumulate channel flags one by one
    for (int n = 0; n < 8; n++) begin
      ch_evt_i = 8'(1 << n); tick(); ch_evt_i = '0;
      peek(6'h0E, v); check("R2 ch", v, (2 << n) - 1);
    end
    ovf_evt_i = 1; tick(); ovf_evt_i = 0;
    peek(6'h0F, v); check("R2 ovf", v, 8'h80);
    check("R3 rsvd", v & 8'h7F, 0);

    // R10
    ch_ie_i = 8'hA5; ovf_ie_i = 1; #1;
    check("R10 ch", ch_irq_o, 8'hA5); check("R10 ovf", ovf_irq_o, 1);
    tick(); tick(); check("R10 level", ch_irq_o, 8'hA5);
    ovf_ie_i = 0; #1; check("R10 ovf off", ovf_irq_o, 0);
    tmr_en_i = 1; acc(0, 1, 6'h0E, 8'h05); tmr_en_i = 0;
    check("R10 after clr", ch_irq_o, 8'hA0);
    ch_ie_i = 0;

    // R4: sweep all masks with the three enable combinations
    for (int m = 0; m < 256; m++) begin
      set_all();
      tmr_en_i = (m % 3) != 1; pac_en_i = (m % 3) != 0;
      acc(0, 1, 6'h0E, 8'(m));
      peek(6'h0E, v); check("R4 mask", v, 8'hFF & ~m);
    end
    set_all();
    acc(0, 1, 6'h0F, 8'h7F); peek(6'h0F, v); check("R4 ovf zero bit", v, 8'h80);
    acc(0, 1, 6'h0F, 8'h80); peek(6'h0F, v); check("R4 ovf clr", v, 0);
    tmr_en_i = 0; pac_en_i = 0;

    // R5: enables low, for both fast-clear settings
    for (int f = 0; f < 2; f++) begin
      fast_clr_i = 1'(f);
      set_all();
      acc(0, 1, 6'h0E, 8'hFF); acc(0, 1, 6'h0F, 8'hFF);
      peek(6'h0E, v); check("R5 ch", v, 8'hFF);
      peek(6'h0F, v); check("R5 ovf", v, 8'h80);
    end
    fast_clr_i = 0;

    // R6: every channel, both bytes, read and write
    fast_clr_i = 1;
    for (int n = 0; n < 8; n++)
      for (int b = 0; b < 2; b++)
        for (int op = 0; op < 2; op++) begin
          set_all();
          acc(op == 0, op == 1, 6'(16 + 2 * n + b), 8'h00);
          peek(6'h0E, v); check("R6 ch", v, 8'hFF & ~(1 << n));
          peek(6'h0F, v); check("R6 ovf kept", v, 8'h80);
        end

    // R7: counter bytes, read and write
    for (int a = 4; a < 6; a++)
      for (int op = 0; op < 2; op++) begin
        set_all();
        acc(op == 0, op == 1, 6'(a), 8'h00);
        peek(6'h0F, v); check("R7 ovf", v, 0);
        peek(6'h0E, v); check("R7 ch kept", v, 8'hFF);
      end

    // R9: collisions
    ch_evt_i = 8'h02; acc(1, 0, 6'h12, 0);
    peek(6'h0E, v); check("R9 fast ch", v, 8'hFF);
    ovf_evt_i = 1; acc(0, 1, 6'h04, 0);
    peek(6'h0F, v); check("R9 fast ovf", v, 8'h80);
    fast_clr_i = 0;
    tmr_en_i = 1;
    ch_evt_i = 8'h0F; acc(0, 1, 6'h0E, 8'hFF);
    peek(6'h0E, v); check("R9 wr ch", v, 8'h0F);
    ovf_evt_i = 1; acc(0, 1, 6'h0F, 8'h80);
    peek(6'h0F, v); check("R9 wr ovf", v, 8'h80);
    tmr_en_i = 0;

    // R8: fast clear off
    set_all();
    for (int a = 4; a < 32; a++) begin
      if (a == 14 || a == 15) continue;
      acc(1, 0, 6'(a), 0); acc(0, 1, 6'(a), 8'hFF);
    end
    peek(6'h0E, v); check("R8 ch", v, 8'hFF);
    peek(6'h0F, v); check("R8 ovf", v, 8'h80);

    // R11: all other offsets read zero
    for (int a = 0; a < 64; a++) begin
      if (a == 14 || a == 15) continue;
      peek(6'(a), v); check("R11 other", v, 0);
    end
    peek(6'h0E, v); check("R11 no side effect", v, 8'hFF);

    clear_all();
    peek(6'h0E, v); check("R4 final", v, 0);
    summary();
  end
endmodule